// File: doc/BRIEF.md
# Banked Data Memory Front End

This block sits between the instruction decoder of a small 8-bit core and its data storage. It serves a 7-bit byte address space split into two regions. The lower region, 00h to 27h, holds the core's special registers. It looks the same whichever bank is active. The upper region, 28h to 7Fh, is general-purpose RAM with one 88-byte copy per bank. The bank is chosen by a bank register that lives in the lower region.

Two locations in the lower region are not storage. They are windows that forward the access to whatever byte a pointer register names. This gives the core indirect addressing with no extra ports. Every cycle the core presents one access. It can be a plain byte write, a single-bit set or a single-bit clear. The bit operations are a read-modify-write that completes within one clock. Read data is always available combinationally for the presented address, so the core's ALU can consume it in the same cycle.

Top module: `bank_dmem`

## Requirements
- R1: After reset every byte of storage, including all pointers, the bank register and both RAM banks, is zero, so every address reads 00h.
- R2: The bank register is at 04h. Its bit 0 picks RAM bank 0 or 1, and its bits 7:1 always read 0. The bytes at 00h to 27h read and write the same regardless of bank.
- R3: Addresses 28h to 7Fh map to 88 bytes of RAM per bank. A write into one bank leaves the same address in the other bank unchanged.
- R4: An access to 00h acts on the byte whose address is bits 6:0 of the pointer at 01h. An access to 02h does the same through the pointer at 03h. Bit 7 of each pointer is stored and read back, but it does not take part in addressing.
- R5: An indirect access whose target address is 00h or 02h reads 00h, and any write or bit operation on it has no effect.
- R6: With the write enable low and the set strobe high, bit `bitIdx` (0 = LSB, 7 = MSB) of the byte at the effective address becomes 1 at the clock edge. The other seven bits keep their values.
- R7: With the write enable low, the clear strobe high and the set strobe low, bit `bitIdx` of the effective byte becomes 0 and the other bits keep their values. The write enable takes precedence over both strobes, and set takes precedence over clear.
- R8: The implemented special registers are 01h, 03h, 04h and the plain storage bytes 05h to 0Bh (05h is the accumulator, 0Ah is the status byte). Every other address from 0Ch to 27h reads 00h and ignores writes and bit operations.
- R9: Read data follows the address and pointer contents combinationally. Writes and bit operations take effect only at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Byte address of the access |
| wdata | input | 8 | Byte written when `we` is high |
| we | input | 1 | Whole-byte write enable |
| bitSet | input | 1 | Set one bit of the addressed byte |
| bitClr | input | 1 | Clear one bit of the addressed byte |
| bitIdx | input | 3 | Bit number for set/clear, 0 = LSB |
| rdata | output | 8 | Combinational read of the addressed byte |

## Verification
The hardest cases to reach are the chained ones. In these an indirect window lands on a pointer, on the bank register or on the other window, so a single access changes how every later address resolves. Bit operations on the bank register through a pointer also switch the visible RAM bank halfway through a sequence. The stimulus aims pointers at 01h, 03h, 04h, 00h and 02h on purpose. It then issues a long mixed run in which addresses are drawn mostly from the lower region. Pointers, windows and the bank register therefore keep changing while the behavioural model tracks every byte.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    OP_NONE,
    OP_LOAD,
    OP_SET,
    OP_CLR
  } opKind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] effAddr;
    logic              isNull;
    opKind_e           op;
    logic [DATA_W-1:0] bitMask;
  } strobe_t;
endpackage

// File: rtl/bdm_ctrl.sv
module bdm_ctrl
  import bdm_pkg::*;
#(
  parameter int WIN0_ADDR = 0,
  parameter int WIN1_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ptr0,
  input  logic [DATA_W-1:0] ptr1,
  input  logic              we,
  input  logic              bitSet,
  input  logic              bitClr,
  input  logic [IDX_W-1:0]  bitIdx,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] WIN0 = ADDR_W'(WIN0_ADDR);
  localparam logic [ADDR_W-1:0] WIN1 = ADDR_W'(WIN1_ADDR);

  logic [ADDR_W-1:0] effAddr;

  always_comb begin
    if (addr == WIN0)      effAddr = ptr0[ADDR_W-1:0];
    else if (addr == WIN1) effAddr = ptr1[ADDR_W-1:0];
    else                   effAddr = addr;
  end

  always_comb begin
    strb.effAddr = effAddr;
    strb.isNull  = (effAddr == WIN0) || (effAddr == WIN1);
    strb.bitMask = DATA_W'(1) << bitIdx;
    if (we)          strb.op = OP_LOAD;
    else if (bitSet) strb.op = OP_SET;
    else if (bitClr) strb.op = OP_CLR;
    else             strb.op = OP_NONE;
  end

  // R6 R7: the bit operations touch exactly one bit
  a_r6_single_bit_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(strb.bitMask) == 1);

  // R7: write enable overrides both bit strobes
  a_r7_load_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (bitSet || bitClr)) |-> (strb.op != OP_SET && strb.op != OP_CLR));
endmodule

// File: rtl/bdm_datapath.sv
module bdm_datapath
  import bdm_pkg::*;
#(
  parameter int SFR_TOP   = 40,
  parameter int NUM_BANKS = 2,
  parameter int PTR0_ADDR = 1,
  parameter int PTR1_ADDR = 3,
  parameter int BANK_ADDR = 4,
  parameter int PLAIN_LO  = 5,
  parameter int PLAIN_HI  = 11,
  parameter int ACC_ADDR  = 5,
  parameter int STAT_ADDR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ptr0,
  output logic [DATA_W-1:0] ptr1
);
  localparam int RAM_DEPTH = (1 << ADDR_W) - SFR_TOP;
  localparam int RAM_IW    = $clog2(RAM_DEPTH);
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int PLAIN_N   = PLAIN_HI - PLAIN_LO + 1;
  localparam int PLAIN_W   = (PLAIN_N > 1) ? $clog2(PLAIN_N) : 1;

  localparam logic [ADDR_W-1:0] A_SFR_TOP = ADDR_W'(SFR_TOP);
  localparam logic [ADDR_W-1:0] A_PTR0    = ADDR_W'(PTR0_ADDR);
  localparam logic [ADDR_W-1:0] A_PTR1    = ADDR_W'(PTR1_ADDR);
  localparam logic [ADDR_W-1:0] A_BANK    = ADDR_W'(BANK_ADDR);
  localparam logic [ADDR_W-1:0] A_PLO     = ADDR_W'(PLAIN_LO);
  localparam logic [ADDR_W-1:0] A_PHI     = ADDR_W'(PLAIN_HI);
  localparam int ACC_IX  = ACC_ADDR - PLAIN_LO;
  localparam int STAT_IX = STAT_ADDR - PLAIN_LO;

  logic [DATA_W-1:0] ptr0Reg, ptr1Reg;
  logic [BANK_W-1:0] bankReg;
  logic [DATA_W-1:0] plainReg [PLAIN_N];
  logic [DATA_W-1:0] bankRd   [NUM_BANKS];

  logic              inRam, isPtr0, isPtr1, isBank, isPlain;
  logic [RAM_IW-1:0] ramIdx;
  logic [PLAIN_W-1:0] plainIdx;
  logic [DATA_W-1:0] curByte, newByte;
  logic              wrEn;

  // address decode
  always_comb begin
    inRam    = strb.effAddr >= A_SFR_TOP;
    isPtr0   = strb.effAddr == A_PTR0;
    isPtr1   = strb.effAddr == A_PTR1;
    isBank   = strb.effAddr == A_BANK;
    isPlain  = (strb.effAddr >= A_PLO) && (strb.effAddr <= A_PHI);
    ramIdx   = RAM_IW'(strb.effAddr - A_SFR_TOP);
    plainIdx = PLAIN_W'(strb.effAddr - A_PLO);
  end

  // read mux
  always_comb begin
    curByte = '0;
    if (strb.isNull)  curByte = '0;
    else if (inRam)   curByte = bankRd[bankReg];
    else if (isPtr0)  curByte = ptr0Reg;
    else if (isPtr1)  curByte = ptr1Reg;
    else if (isBank)  curByte = DATA_W'(bankReg);
    else if (isPlain) curByte = plainReg[plainIdx];
  end

  // modify stage of the read-modify-write
  always_comb begin
    unique case (strb.op)
      OP_LOAD: newByte = wdata;
      OP_SET:  newByte = curByte | strb.bitMask;
      OP_CLR:  newByte = curByte & ~strb.bitMask;
      default: newByte = curByte;
    endcase
    wrEn = (strb.op != OP_NONE) && !strb.isNull;
  end

  assign rdata = curByte;
  assign ptr0  = ptr0Reg;
  assign ptr1  = ptr1Reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr0Reg <= '0;
      ptr1Reg <= '0;
      bankReg <= '0;
    end else if (wrEn && !inRam) begin
      if (isPtr0) ptr0Reg <= newByte;
      if (isPtr1) ptr1Reg <= newByte;
      if (isBank) bankReg <= newByte[BANK_W-1:0];
    end
  end

  for (genvar p = 0; p < PLAIN_N; p++) begin : g_plain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        plainReg[p] <= '0;
      else if (wrEn && !inRam && isPlain && plainIdx == PLAIN_W'(p))
        plainReg[p] <= newByte;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [RAM_DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < RAM_DEPTH; i++) mem[i] <= '0;
      end else if (wrEn && inRam && bankReg == BANK_W'(b)) begin
        mem[ramIdx] <= newByte;
      end
    end
    assign bankRd[b] = mem[ramIdx];
  end

  // R5: a window aimed at a window yields zero
  a_r5_null_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strb.isNull |-> rdata == '0);

  // R2: only the select bit of the bank register is visible
  a_r2_bank_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (isBank && !strb.isNull) |-> rdata[DATA_W-1:BANK_W] == '0);

  // R8: unimplemented special addresses read zero
  a_r8_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!inRam && !isPtr0 && !isPtr1 && !isBank && !isPlain) |-> rdata == '0);

  // R6: a set on the accumulator leaves the chosen bit high
  a_r6_acc_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.op == OP_SET && !strb.isNull && strb.effAddr == ADDR_W'(ACC_ADDR))
    |=> (plainReg[ACC_IX] & $past(strb.bitMask)) == $past(strb.bitMask));

  // R7: a clear on the status byte leaves the chosen bit low
  a_r7_stat_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.op == OP_CLR && !strb.isNull && strb.effAddr == ADDR_W'(STAT_ADDR))
    |=> (plainReg[STAT_IX] & $past(strb.bitMask)) == '0);

  // R9: with no operation presented, the accumulator holds
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.op == OP_NONE) |=> $stable(plainReg[ACC_IX]));
endmodule

// File: rtl/bank_dmem.sv
module bank_dmem
  import bdm_pkg::*;
#(
  parameter int SFR_TOP   = 40,
  parameter int NUM_BANKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              bitSet,
  input  logic              bitClr,
  input  logic [IDX_W-1:0]  bitIdx,
  output logic [DATA_W-1:0] rdata
);
  strobe_t           strb;
  logic [DATA_W-1:0] ptr0, ptr1;

  bdm_ctrl #(
    .WIN0_ADDR(0),
    .WIN1_ADDR(2)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .ptr0   (ptr0),
    .ptr1   (ptr1),
    .we     (we),
    .bitSet (bitSet),
    .bitClr (bitClr),
    .bitIdx (bitIdx),
    .strb   (strb)
  );

  bdm_datapath #(
    .SFR_TOP   (SFR_TOP),
    .NUM_BANKS (NUM_BANKS),
    .PTR0_ADDR (1),
    .PTR1_ADDR (3),
    .BANK_ADDR (4),
    .PLAIN_LO  (5),
    .PLAIN_HI  (11),
    .ACC_ADDR  (5),
    .STAT_ADDR (10)
  ) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strb  (strb),
    .wdata (wdata),
    .rdata (rdata),
    .ptr0  (ptr0),
    .ptr1  (ptr1)
  );
endmodule

// File: tb/bank_dmem_bench.sv
module bank_dmem_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, bitSet = 1'b0, bitClr = 1'b0;
  logic [2:0] bitIdx = '0;
  logic [7:0] rdata;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int mp0, mp1, mbank;
  int msp [12];
  int mram [2][88];

  bank_dmem u_bank_dmem (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
    .bitSet(bitSet), .bitClr(bitClr), .bitIdx(bitIdx), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int effOf(int a);
    if (a == 0) return mp0 & 127;
    if (a == 2) return mp1 & 127;
    return a;
  endfunction

  function automatic int mread(int e);
    if (e == 0 || e == 2) return 0;
    if (e >= 40) return mram[mbank][e-40];
    if (e == 1) return mp0;
    if (e == 3) return mp1;
    if (e == 4) return mbank;
    if (e >= 5 && e <= 11) return msp[e];
    return 0;
  endfunction

  function automatic void mwrite(int e, int v);
    if (e == 0 || e == 2) return;
    if (e >= 40) mram[mbank][e-40] = v;
    else if (e == 1) mp0 = v;
    else if (e == 3) mp1 = v;
    else if (e == 4) mbank = v & 1;
    else if (e >= 5 && e <= 11) msp[e] = v;
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s addr=%02h actual=%02h expected=%02h", tag, addr, act, exp);
    end
  endtask

  // one access: drive at falling edge, compare combinational read, apply at rising edge
  task automatic op(string tag, int a, int wd, bit w, bit s, bit c, int idx);
    int e, old, nv;
    @(negedge clk);
    addr = 7'(a); wdata = 8'(wd); we = w; bitSet = s; bitClr = c; bitIdx = 3'(idx);
    #1;
    e = effOf(a);
    check(tag, int'(rdata), mread(e));
    @(posedge clk);
    old = mread(e);
    if (w)      nv = wd & 255;
    else if (s) nv = old | (1 << idx);
    else if (c) nv = old & ~(1 << idx) & 255;
    else        nv = -1;
    if (nv >= 0) mwrite(e, nv);
  endtask

  task automatic rd(string tag, int a);
    op(tag, a, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(string tag, int a, int v);
    op(tag, a, v, 1, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    mp0 = 0; mp1 = 0; mbank = 0;
    for (int i = 0; i < 12; i++) msp[i] = 0;
    for (int b = 0; b < 2; b++) for (int i = 0; i < 88; i++) mram[b][i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", int'(rdata), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every address zero after reset
    for (int a = 0; a < 128; a++) rd("R1 reset read", a);

    // R2: special area mirrored, bank register keeps only bit 0
    wr("R2 acc", 5, 8'h5a);
    wr("R2 status", 10, 8'hc3);
    wr("R2 bank", 4, 8'hff);
    rd("R2 bank upper", 4);
    rd("R2 acc in bank1", 5);
    rd("R2 status in bank1", 10);
    wr("R2 ptr in bank1", 1, 8'h2c);
    wr("R2 bank", 4, 8'h00);
    rd("R2 ptr in bank0", 1);

    // R3: banks hold independent RAM
    for (int a = 40; a < 128; a += 7) wr("R3 fill bank0", a, a ^ 8'h33);
    wr("R3 bank", 4, 1);
    for (int a = 40; a < 128; a += 7) rd("R3 bank1 untouched", a);
    for (int a = 40; a < 128; a += 7) wr("R3 fill bank1", a, a + 8'h40);
    wr("R3 bank", 4, 0);
    for (int a = 40; a < 128; a += 7) rd("R3 bank0 kept", a);
    rd("R3 first byte", 40);
    rd("R3 last byte", 127);

    // R4: windows through pointers, bit 7 of pointer ignored for addressing
    wr("R4 ptr0", 1, 8'hc7);
    wr("R4 via win0", 0, 8'h99);
    rd("R4 direct 47h", 8'h47);
    wr("R4 ptr1", 3, 8'h05);
    rd("R4 win1 acc", 2);
    op("R4 win1 write acc", 2, 8'h11, 1, 0, 0, 0);
    rd("R4 acc", 5);
    wr("R4 ptr1 to bank", 3, 8'h04);
    wr("R4 bank via win1", 2, 1);
    rd("R4 bank1 via win0", 0);
    wr("R4 ptr0 self", 1, 8'h01);
    rd("R4 win0 reads ptr0", 0);
    wr("R4 retarget ptr0", 0, 8'h60);
    rd("R4 ptr0 after", 1);

    // R5: window aimed at a window
    wr("R5 ptr0 null", 1, 8'h02);
    op("R5 write null", 0, 8'hee, 1, 0, 0, 0);
    op("R5 set null", 0, 0, 0, 1, 0, 3);
    rd("R5 read null", 0);
    wr("R5 ptr1 null", 3, 8'h80);
    op("R5 write null1", 2, 8'h77, 1, 0, 0, 0);
    rd("R5 read null1", 2);
    rd("R5 ptr1 intact", 3);

    // R6/R7: bit operations and priority
    wr("R6 acc zero", 5, 0);
    for (int i = 0; i < 8; i++) op("R6 set acc", 5, 0, 0, 1, 0, i);
    rd("R6 acc full", 5);
    for (int i = 0; i < 8; i += 2) op("R7 clr acc", 5, 0, 0, 0, 1, i);
    rd("R7 acc pattern", 5);
    op("R7 set beats clr", 10, 0, 0, 1, 1, 6);
    op("R7 clr status", 10, 0, 0, 0, 1, 7);
    rd("R7 status", 10);
    op("R7 we beats strobes", 11, 8'h3c, 1, 1, 1, 0);
    rd("R7 after we", 11);
    op("R6 set bank bit", 4, 0, 0, 1, 0, 0);
    rd("R6 bank set", 4);
    op("R7 clr bank bit", 4, 0, 0, 0, 1, 0);
    op("R6 set upper bank bit", 4, 0, 0, 1, 0, 5);
    rd("R6 bank upper stays", 4);
    wr("R6 ptr0 ram", 1, 8'h30);
    op("R6 set via win", 0, 0, 0, 1, 0, 7);
    rd("R6 ram bit7", 8'h30);
    op("R6 set ptr bit", 1, 0, 0, 1, 0, 3);
    rd("R6 ptr0 moved", 1);

    // R8: holes in the special area
    for (int a = 12; a < 40; a++) wr("R8 hole write", a, a + 1);
    for (int a = 12; a < 40; a++) op("R8 hole set", a, 0, 0, 1, 0, a & 7);
    for (int a = 12; a < 40; a++) rd("R8 hole read", a);

    // R9: read follows pointer change combinationally, writes wait for the edge
    wr("R9 ptr1", 3, 8'h50);
    rd("R9 follow", 2);
    wr("R9 ptr1 again", 3, 8'h51);
    rd("R9 follow2", 2);

    // mixed run, addresses biased to the special area
    for (int n = 0; n < 3000; n++) begin
      int a, k;
      k = int'($urandom_range(0, 9));
      a = (k < 5) ? int'($urandom_range(0, 12)) : int'($urandom_range(0, 127));
      op("R9 mixed", a, int'($urandom_range(0, 255)), ($urandom_range(0, 3) == 0),
         ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
         int'($urandom_range(0, 7)));
    end
    for (int a = 0; a < 128; a++) rd("R3 final sweep", a);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule